// File: doc/BRIEF.md
# Refresh Counter with Skip Control

This block is the refresh bookkeeping inside a DRAM device. It holds the internal refresh pointer that names the rows the next refresh covers. It decodes refresh-class commands from a simplified command interface. A real refresh advances the pointer and blocks the banks for the refresh completion time. A skip refresh advances the pointer only, with no bank activity. A pointer read returns the current value on a data port. A pointer write loads a new value from outside.

A memory controller can use these commands to skip refresh bins that need no refresh in the current retention round. It can also recover the pointer after self-refresh and align several devices of a rank. Refresh granularity can be full, half or quarter, and the banks can be refreshed all at once or one at a time. While the device is in self-refresh, an internal timer pulse advances the pointer without any command.

Top module: `refresh_counter_ctl`

## Requirements
- R1: After reset the pointer and the bank index are 0, and `busy`, `bank_busy`, `rd_valid` and `proto_err` are low.
- R2: A refresh command (`cmd_kind`=1) with `cmd_skip`=0 in all-bank mode sets every bit of `bank_busy` and raises `busy` from the next cycle on. Both stay high for exactly 384 cycles in `gran`=0, 280 in `gran`=1 and 208 in `gran`=2.
- R3: A refresh command with `cmd_skip`=1 advances the pointer exactly like a real refresh but never raises `busy`, and a new command is accepted in the very next cycle.
- R4: The pointer step per refresh is 4 for `gran`=0 (and for the unused code 3), 2 for `gran`=1 and 1 for `gran`=2. The 15-bit pointer wraps modulo 32768.
- R5: A read command (`cmd_kind`=2) makes `rd_valid` high for one cycle on the next cycle, with `rd_data` equal to the pointer value at the command.
- R6: A write command (`cmd_kind`=3) replaces the pointer with `cmd_wdata`.
- R7: With `per_bank` high, a real refresh raises only `bank_busy` bit `b` for 200 cycles, where `b` is the bank index. Each real or skip refresh advances the bank index, and the pointer advances by its step only when the index wraps from 15 to 0.
- R8: While `self_ref` is high, each `sr_tick` pulse advances the pointer by 4 whatever the granularity.
- R9: A refresh, read or write command received while `busy` or `self_ref` is high pulses `proto_err` on the next cycle. It changes neither the pointer, the bank index nor the busy state, and it produces no read data.
- R10: A command with `cmd_kind`=0 is ignored: no error, no pointer change, no busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_kind | input | 2 | 0 other, 1 refresh, 2 pointer read, 3 pointer write |
| cmd_skip | input | 1 | Address flag: turns a refresh into a skip refresh |
| cmd_wdata | input | 15 | Value for a pointer write |
| gran | input | 2 | 0 full, 1 half, 2 quarter granularity |
| per_bank | input | 1 | Refresh one bank per command |
| self_ref | input | 1 | Device is in self-refresh |
| sr_tick | input | 1 | Internal self-refresh event pulse |
| busy | output | 1 | A refresh is in progress |
| bank_busy | output | 16 | Banks currently being refreshed |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 15 | Pointer value returned by a read |
| proto_err | output | 1 | Command rejected during busy or self-refresh |

## Verification
On every cycle the assertions check the shape of the busy mask (empty, a single bank or all banks), the run length of busy against the longest completion time, and that an accepted real refresh raises busy while a skip refresh does not. They also check that a rejected command leaves the pointer unchanged and raises the error, and that a read returns the pointer it was issued against. The exact completion times for each granularity and for per-bank mode, the bank index wrap that gates the pointer, the pointer wrap, and the self-refresh step are shown only by the bench scenarios. Those scenarios carry a pointer model and count busy cycles.

// File: rtl/refresh_counter_ctl.sv
module refresh_counter_ctl #(
  parameter int CW      = 15,
  parameter int NB      = 16,
  parameter int T_RFC1  = 384,
  parameter int T_RFC2  = 280,
  parameter int T_RFC4  = 208,
  parameter int T_RFCPB = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_kind,
  input  logic          cmd_skip,
  input  logic [CW-1:0] cmd_wdata,
  input  logic [1:0]    gran,
  input  logic          per_bank,
  input  logic          self_ref,
  input  logic          sr_tick,
  output logic          busy,
  output logic [NB-1:0] bank_busy,
  output logic          rd_valid,
  output logic [CW-1:0] rd_data,
  output logic          proto_err
);

  localparam int BW    = (NB > 1) ? $clog2(NB) : 1;
  localparam int TM12  = (T_RFC1 > T_RFC2) ? T_RFC1 : T_RFC2;
  localparam int TM4P  = (T_RFC4 > T_RFCPB) ? T_RFC4 : T_RFCPB;
  localparam int TMAX  = (TM12 > TM4P) ? TM12 : TM4P;
  localparam int TW    = $clog2(TMAX + 1);

  localparam logic [1:0] K_NOP = 2'd0;
  localparam logic [1:0] K_REF = 2'd1;
  localparam logic [1:0] K_RD  = 2'd2;
  localparam logic [1:0] K_WR  = 2'd3;

  logic [CW-1:0] cnt;
  logic [BW-1:0] bank;
  logic [BW-1:0] busy_idx;
  logic [TW-1:0] tmr;
  logic          busy_r;
  logic          busy_pb;
  logic [CW-1:0] step;
  logic [TW-1:0] t_len;

  wire cls      = cmd_valid && (cmd_kind != K_NOP);
  wire blocked  = busy_r || self_ref;
  wire take     = cls && !blocked;
  wire bank_end = (bank == BW'(NB - 1));
  wire row_adv  = !per_bank || bank_end;
  wire sr_step  = self_ref && sr_tick;

  always_comb begin
    case (gran)
      2'd1:    step = CW'(2);
      2'd2:    step = CW'(1);
      default: step = CW'(4);
    endcase
  end

  always_comb begin
    if (per_bank) t_len = TW'(T_RFCPB - 1);
    else begin
      case (gran)
        2'd1:    t_len = TW'(T_RFC2 - 1);
        2'd2:    t_len = TW'(T_RFC4 - 1);
        default: t_len = TW'(T_RFC1 - 1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      bank      <= '0;
      busy_idx  <= '0;
      tmr       <= '0;
      busy_r    <= 1'b0;
      busy_pb   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      proto_err <= 1'b0;
    end else begin
      rd_valid  <= 1'b0;
      proto_err <= cls && blocked;
      if (busy_r) begin
        if (tmr == '0) busy_r <= 1'b0;
        else           tmr <= tmr - 1'b1;
      end
      if (sr_step) begin
        cnt <= cnt + CW'(4);
      end else if (take) begin
        case (cmd_kind)
          K_REF: begin
            if (row_adv) cnt <= cnt + step;
            if (per_bank) bank <= bank_end ? '0 : bank + 1'b1;
            if (!cmd_skip) begin
              busy_r   <= 1'b1;
              tmr      <= t_len;
              busy_pb  <= per_bank;
              busy_idx <= bank;
            end
          end
          K_RD: begin
            rd_data  <= cnt;
            rd_valid <= 1'b1;
          end
          K_WR:    cnt <= cmd_wdata;
          default: ;
        endcase
      end
    end
  end

  assign busy      = busy_r;
  assign bank_busy = !busy_r ? '0 : (busy_pb ? (NB'(1) << busy_idx) : '1);

  logic [TW:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  p_mask_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_busy == '0) || ($countones(bank_busy) == 1) || (&bank_busy));

  p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < (TW+1)'(TMAX)));

  p_real_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_kind == K_REF && !cmd_skip && !sr_step) |=> busy);

  p_skip_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_kind == K_REF && cmd_skip) |=> !busy);

  p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cls && blocked && !sr_step) |=> (proto_err && $stable(cnt) && !rd_valid));

  p_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_kind == K_RD && !sr_step) |=> (rd_valid && rd_data == $past(cnt)));

  p_sr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_step |=> (cnt == $past(cnt) + CW'(4)));

endmodule

// File: tb/test_refresh_counter_ctl.sv
module test_refresh_counter_ctl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_kind = 0;
  logic        cmd_skip = 0;
  logic [14:0] cmd_wdata = 0;
  logic [1:0]  gran = 0;
  logic        per_bank = 0;
  logic        self_ref = 0;
  logic        sr_tick = 0;
  logic        busy;
  logic [15:0] bank_busy;
  logic        rd_valid;
  logic [14:0] rd_data;
  logic        proto_err;

  int total = 0;
  int fails = 0;
  logic [14:0] exp_cnt = 0;

  refresh_counter_ctl i_refresh_counter_ctl (
    .clk, .rst_n, .cmd_valid, .cmd_kind, .cmd_skip, .cmd_wdata, .gran,
    .per_bank, .self_ref, .sr_tick, .busy, .bank_busy, .rd_valid, .rd_data,
    .proto_err
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic s, input logic [14:0] w);
    cmd_valid = 1; cmd_kind = k; cmd_skip = s; cmd_wdata = w;
    @(negedge clk);
    cmd_valid = 0; cmd_kind = 0; cmd_skip = 0; cmd_wdata = 0;
  endtask

  task automatic read_cnt(input string req, input int exp);
    issue(2'd2, 0, 0);
    chk({req, " rd_valid"}, rd_valid, 1);
    chk({req, " rd_data"}, rd_data, exp);
  endtask

  task automatic busy_len(input string req, input int exp);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk({req, " busy length"}, n, exp);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 bank_busy", bank_busy, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 proto_err", proto_err, 0);
    read_cnt("R1 pointer", 0);
  endtask

  task automatic t_full_refresh;
    int lens[3] = '{384, 280, 208};
    int steps[3] = '{4, 2, 1};
    for (int g = 0; g < 3; g++) begin
      gran = 2'(g);
      issue(2'd1, 0, 0);
      exp_cnt += 15'(steps[g]);
      chk("R2 all banks busy", bank_busy, 16'hFFFF);
      busy_len("R2", lens[g]);
      read_cnt("R4 step", exp_cnt);
    end
    gran = 0;
  endtask

  task automatic t_skip;
    gran = 0;
    issue(2'd1, 1, 0);
    exp_cnt += 4;
    chk("R3 no busy", busy, 0);
    issue(2'd1, 1, 0);
    exp_cnt += 4;
    chk("R3 back-to-back no error", proto_err, 0);
    gran = 2'd3;
    issue(2'd1, 1, 0);
    exp_cnt += 4;
    gran = 0;
    read_cnt("R3 R4 skip advance", exp_cnt);
  endtask

  task automatic t_write_wrap;
    issue(2'd3, 0, 15'h7FFE);
    exp_cnt = 15'h7FFE;
    read_cnt("R6 write", exp_cnt);
    issue(2'd1, 1, 0);
    exp_cnt += 4;
    read_cnt("R4 wrap", exp_cnt);
    chk("R4 wrap value", exp_cnt, 2);
  endtask

  task automatic t_reject;
    issue(2'd1, 0, 0);
    exp_cnt += 4;
    issue(2'd3, 0, 15'h1234);
    chk("R9 error on write", proto_err, 1);
    issue(2'd2, 0, 0);
    chk("R9 error on read", proto_err, 1);
    chk("R9 no read data", rd_valid, 0);
    issue(2'd1, 1, 0);
    chk("R9 error on skip", proto_err, 1);
    issue(2'd0, 0, 0);
    chk("R10 no error for other", proto_err, 0);
    busy_len("R9 busy unchanged", 384 - 4);
    read_cnt("R9 pointer unchanged", exp_cnt);
    issue(2'd0, 1, 15'h55);
    chk("R10 no busy", busy, 0);
    read_cnt("R10 pointer unchanged", exp_cnt);
  endtask

  task automatic t_per_bank;
    per_bank = 1; gran = 2'd1;
    issue(2'd1, 0, 0);
    chk("R7 bank 0 only", bank_busy, 16'h0001);
    busy_len("R7 per-bank", 200);
    for (int i = 1; i < 15; i++) issue(2'd1, 1, 0);
    read_cnt("R7 pointer held", exp_cnt);
    issue(2'd1, 0, 0);
    chk("R7 bank 15 only", bank_busy, 16'h8000);
    exp_cnt += 2;
    busy_len("R7 per-bank last", 200);
    read_cnt("R7 advance on wrap", exp_cnt);
    issue(2'd1, 0, 0);
    chk("R7 back at bank 0", bank_busy, 16'h0001);
    busy_len("R7 per-bank again", 200);
    per_bank = 0; gran = 0;
  endtask

  task automatic t_self_ref;
    self_ref = 1; gran = 2'd2;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      sr_tick = 1; @(negedge clk); sr_tick = 0; @(negedge clk);
    end
    exp_cnt += 12;
    issue(2'd1, 0, 0);
    chk("R9 command in self-refresh", proto_err, 1);
    chk("R9 no busy in self-refresh", busy, 0);
    self_ref = 0; gran = 0;
    @(negedge clk);
    read_cnt("R8 self-refresh step", exp_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_refresh();
    t_skip();
    t_write_wrap();
    t_reject();
    t_per_bank();
    t_self_ref();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #600000;
    total++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule